// File: doc/BRIEF.md
# Line Test Pattern Inserter

This block sits in the serial transmit path of a T1 or E1 line interface. It passes the one-bit transmit stream through, or it replaces that stream with a test pattern: all ones, all zeros, a pseudo-random sequence, or a short programmable loopback code that repeats. Software programs a control register and a code register through a small write port. A mode input chooses E1 or T1 operation, and that choice picks which pseudo-random generator is used. A loss-of-signal input can force all ones onto the line while the block is otherwise passing traffic.

The block has no clock of its own for the pattern. It runs on the system clock and takes two one-cycle enables, one from the transmit clock domain and one from the master clock. A control bit chooses which enable steps the block. The output stage is registered. A second registered output carries the pseudo-random reference bit, with the same optional inversion, for use by a pattern detector.

Top module: `line_pattern_inserter`

## Requirements
- R1: After reset every control field is 0 and the code register holds 5'b00001. Both outputs are 0 until the first active step.
- R2: Control register (address 0): bits [1:0] select the pattern, bit 2 chooses the step enable, bit 3 inverts the random data and bit 4 enables automatic all ones. With pattern 00 and bit 2 = 0, tx_data_o takes the value tx_data_i had at the previous active step.
- R3: With pattern 00 and bit 2 = 1, each active step drives 0, unless R9 applies.
- R4: Pattern 01 drives 1 on every active step.
- R5: Pattern 10 with t1_mode = 0 drives a 15-bit LFSR. Its seed is all ones. It shifts toward the MSB and the MSB is sent. The new LSB is bit14 XOR bit13.
- R6: Pattern 10 with t1_mode = 1 drives a 20-bit LFSR. Its seed is all ones and the new LSB is bit19 XOR bit16. The sent bit is the MSB, except after 14 consecutive sent zeros, when a 1 is sent instead.
- R7: Pattern 11 sends the 5-bit code register (address 1, bits [4:0]) MSB first and repeats it every 5 steps. Sending restarts at bit 4 whenever the pattern select changes.
- R8: When bit 3 is set, the random bit is inverted both on tx_data_o (pattern 10) and on det_ref_o. det_ref_o updates on every active step in every pattern.
- R9: Automatic all ones (bit 4 = 1) forces tx_data_o to 1 while los is 1, but only with pattern 00. The other patterns ignore bit 4 and los.
- R10: An active step is a cycle where mclk_en is high (control bit 2 = 1) or tclk_en is high (bit 2 = 0). Between active steps both outputs hold, and the other enable has no effect.
- R11: A write that changes the pattern select reseeds both LFSRs and clears the zero-run count. A write that leaves the select unchanged does neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tclk_en | input | 1 | Step enable from the transmit clock |
| mclk_en | input | 1 | Step enable from the master clock |
| t1_mode | input | 1 | 1 = T1 random sequence, 0 = E1 |
| los | input | 1 | Loss of signal indication |
| tx_data_i | input | 1 | Serial transmit data |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | 0 = control, 1 = loopback code |
| cfg_wdata | input | 8 | Configuration write data |
| tx_data_o | output | 1 | Serial data to the line |
| det_ref_o | output | 1 | Random reference bit for a detector |

## Verification
The assertions assume that a configuration write and an active step never fall in the same cycle, so each step sees one settled control value. They also assume that t1_mode only changes before the pattern select is written, so the zero-run check starts from a reseed. The stimulus drops both enables for every write and sets the mode before it selects the random pattern. Reference bits come from an independent bench model of the two generators and the code rotator.

// File: rtl/lpi_pkg.sv
package lpi_pkg;
  typedef enum logic [1:0] {
    PAT_PASS = 2'b00,
    PAT_ONES = 2'b01,
    PAT_PRBS = 2'b10,
    PAT_LOOP = 2'b11
  } pat_sel_e;

  typedef struct packed {
    logic     auto_ones;
    logic     prbs_inv;
    logic     ref_sel;
    pat_sel_e pat;
  } ctrl_t;

  localparam int CFG_DW = 8;
endpackage

// File: rtl/lpi_cfg_regs.sv
module lpi_cfg_regs
  import lpi_pkg::*;
#(
  parameter int DW = CFG_DW,
  parameter int CODE_W = 5,
  parameter logic [CODE_W-1:0] CODE_RST = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              addr,
  input  logic [DW-1:0]     wdata,
  output ctrl_t             ctrl,
  output logic [CODE_W-1:0] code,
  output logic              reseed
);
  localparam int CTRL_W = $bits(ctrl_t);

  assign reseed = we && !addr && (pat_sel_e'(wdata[1:0]) != ctrl.pat);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
      code <= CODE_RST;
    end else if (we) begin
      if (addr) code <= wdata[CODE_W-1:0];
      else      ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
    end
  end

  assert_ctrl_reset_R1: assert property (@(posedge clk)
    rst |=> (ctrl == '0) && (code == CODE_RST));
endmodule

// File: rtl/lpi_lfsr_gen.sv
module lpi_lfsr_gen #(
  parameter int W = 15,
  parameter int TAP_A = 14,
  parameter int TAP_B = 13,
  parameter logic [W-1:0] SEED = '1,
  parameter int ZLIM = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic reseed,
  output logic bit_o
);
  logic [W-1:0] state;

  always_ff @(posedge clk) begin
    if (rst || reseed)  state <= SEED;
    else if (adv)       state <= {state[W-2:0], state[TAP_A] ^ state[TAP_B]};
  end

  generate
    if (ZLIM > 0) begin : g_zlim
      localparam int ZW = $clog2(ZLIM + 1);
      logic [ZW-1:0] zrun;
      assign bit_o = (zrun == ZW'(ZLIM)) | state[W-1];
      always_ff @(posedge clk) begin
        if (rst || reseed)  zrun <= '0;
        else if (adv)       zrun <= bit_o ? '0 : zrun + 1'b1;
      end
      assert_zrun_bound_R6: assert property (@(posedge clk) disable iff (rst)
        zrun <= ZW'(ZLIM));
    end else begin : g_plain
      assign bit_o = state[W-1];
    end
  endgenerate

  assert_reseed_R11: assert property (@(posedge clk) disable iff (rst)
    reseed |=> state == SEED);
  assert_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
    state != '0);
endmodule

// File: rtl/lpi_loop_code_gen.sv
module lpi_loop_code_gen #(
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              restart,
  input  logic [CODE_W-1:0] code,
  output logic              bit_o
);
  localparam int IW = (CODE_W > 1) ? $clog2(CODE_W) : 1;
  localparam logic [IW-1:0] TOP = IW'(CODE_W - 1);

  logic [IW-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst || restart)  idx <= TOP;
    else if (adv)        idx <= (idx == '0) ? TOP : idx - 1'b1;
  end

  assign bit_o = code[idx];

  assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
    restart |=> idx == TOP);
  assert_idx_range_R7: assert property (@(posedge clk) disable iff (rst)
    idx <= TOP);
endmodule

// File: rtl/line_pattern_inserter.sv
module line_pattern_inserter
  import lpi_pkg::*;
#(
  parameter int DW = CFG_DW,
  parameter int CODE_W = 5,
  parameter logic [CODE_W-1:0] CODE_RST = 1,
  parameter int ZLIM = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tclk_en,
  input  logic          mclk_en,
  input  logic          t1_mode,
  input  logic          los,
  input  logic          tx_data_i,
  input  logic          cfg_we,
  input  logic          cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic          tx_data_o,
  output logic          det_ref_o
);
  ctrl_t             ctrl;
  logic [CODE_W-1:0] code;
  logic              reseed;
  logic              adv;
  logic              e1_bit, t1_bit, loop_bit, prbs_ref, src;

  lpi_cfg_regs #(.DW(DW), .CODE_W(CODE_W), .CODE_RST(CODE_RST)) cfg_i (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .ctrl(ctrl), .code(code), .reseed(reseed)
  );

  assign adv = ctrl.ref_sel ? mclk_en : tclk_en;

  lpi_lfsr_gen #(.W(15), .TAP_A(14), .TAP_B(13), .SEED('1), .ZLIM(0)) e1_gen_i (
    .clk(clk), .rst(rst), .adv(adv), .reseed(reseed), .bit_o(e1_bit)
  );

  lpi_lfsr_gen #(.W(20), .TAP_A(19), .TAP_B(16), .SEED('1), .ZLIM(ZLIM)) t1_gen_i (
    .clk(clk), .rst(rst), .adv(adv), .reseed(reseed), .bit_o(t1_bit)
  );

  lpi_loop_code_gen #(.CODE_W(CODE_W)) loop_i (
    .clk(clk), .rst(rst), .adv(adv), .restart(reseed), .code(code), .bit_o(loop_bit)
  );

  assign prbs_ref = (t1_mode ? t1_bit : e1_bit) ^ ctrl.prbs_inv;

  always_comb begin
    unique case (ctrl.pat)
      PAT_PASS: begin
        if (ctrl.auto_ones && los) src = 1'b1;
        else if (ctrl.ref_sel)     src = 1'b0;
        else                       src = tx_data_i;
      end
      PAT_ONES: src = 1'b1;
      PAT_PRBS: src = prbs_ref;
      default:  src = loop_bit;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_data_o <= 1'b0;
      det_ref_o <= 1'b0;
    end else if (adv) begin
      tx_data_o <= src;
      det_ref_o <= prbs_ref;
    end
  end

  // Checks on the assembled data path
  int zero_run;
  always_ff @(posedge clk) begin
    if (rst || reseed || !(ctrl.pat == PAT_PRBS && t1_mode && !ctrl.prbs_inv))
      zero_run <= 0;
    else if (adv)
      zero_run <= src ? 0 : zero_run + 1;
  end

  assert_zero_run_R6: assert property (@(posedge clk) disable iff (rst)
    zero_run <= ZLIM);
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (ctrl.ref_sel ? !mclk_en : !tclk_en) |=> $stable(tx_data_o) && $stable(det_ref_o));
  assert_all_ones_R4: assert property (@(posedge clk) disable iff (rst)
    (adv && ctrl.pat == PAT_ONES && !cfg_we) |=> tx_data_o);
  assert_zeros_R3: assert property (@(posedge clk) disable iff (rst)
    (adv && ctrl.pat == PAT_PASS && ctrl.ref_sel && !(ctrl.auto_ones && los)) |=> !tx_data_o);
  assert_auto_ones_R9: assert property (@(posedge clk) disable iff (rst)
    (adv && ctrl.pat == PAT_PASS && ctrl.auto_ones && los) |=> tx_data_o);
endmodule

// File: tb/line_pattern_inserter_tb_top.sv
module line_pattern_inserter_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tclk_en = 0, mclk_en = 0, t1_mode = 0, los = 0, tx_data_i = 0;
  logic cfg_we = 0, cfg_addr = 0;
  logic [7:0] cfg_wdata = '0;
  logic tx_data_o, det_ref_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  line_pattern_inserter dut_i (
    .clk(clk), .rst(rst), .tclk_en(tclk_en), .mclk_en(mclk_en), .t1_mode(t1_mode),
    .los(los), .tx_data_i(tx_data_i), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .tx_data_o(tx_data_o), .det_ref_o(det_ref_o)
  );

  // reference model state
  bit [1:0]  m_pat;
  bit        m_ref, m_inv, m_auto;
  bit [4:0]  m_code;
  bit [14:0] m_l15;
  bit [19:0] m_l20;
  int        m_zc, m_idx;
  bit        m_out, m_det;

  bit    q_o[$];
  bit    q_d[$];
  string q_tag[$];

  task automatic check(input string tag, input bit act, input bit exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic model_reseed();
    m_l15 = '1; m_l20 = '1; m_zc = 0; m_idx = 4;
  endtask

  task automatic step(input bit te, input bit me, input bit d, input bit l,
                      input bit we, input bit a, input bit [7:0] wd, input string tag);
    bit adv, e1b, t1b, pr, srcb;
    @(negedge clk);
    tclk_en = te; mclk_en = me; tx_data_i = d; los = l;
    cfg_we = we; cfg_addr = a; cfg_wdata = wd;
    adv = m_ref ? me : te;
    if (adv) begin
      e1b = m_l15[14];
      t1b = (m_zc == 14) ? 1'b1 : m_l20[19];
      pr  = (t1_mode ? t1b : e1b) ^ m_inv;
      case (m_pat)
        2'b00: srcb = (m_auto && l) ? 1'b1 : (m_ref ? 1'b0 : d);
        2'b01: srcb = 1'b1;
        2'b10: srcb = pr;
        default: srcb = m_code[m_idx];
      endcase
      m_out = srcb; m_det = pr;
      m_l15 = {m_l15[13:0], m_l15[14] ^ m_l15[13]};
      m_l20 = {m_l20[18:0], m_l20[19] ^ m_l20[16]};
      m_zc  = t1b ? 0 : m_zc + 1;
      m_idx = (m_idx == 0) ? 4 : m_idx - 1;
    end
    if (we) begin
      if (a) m_code = wd[4:0];
      else begin
        if (wd[1:0] != m_pat) model_reseed();
        m_pat = wd[1:0]; m_ref = wd[2]; m_inv = wd[3]; m_auto = wd[4];
      end
    end
    q_o.push_back(m_out);
    q_d.push_back(m_det);
    q_tag.push_back(tag);
  endtask

  task automatic wr(input bit a, input bit [7:0] wd, input string tag);
    step(0, 0, 0, los, 1, a, wd, tag);
  endtask

  // monitor: compares one queued expectation per cycle, 2 ns after the edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q_o.size() > 0) begin
        string t;
        bit eo, ed;
        eo = q_o.pop_front(); ed = q_d.pop_front(); t = q_tag.pop_front();
        check(t, tx_data_o, eo, "tx_data_o");
        check(t, det_ref_o, ed, "det_ref_o");
      end
    end
  end

  initial begin
    #1900000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_pat = 0; m_ref = 0; m_inv = 0; m_auto = 0; m_code = 5'b00001;
    m_out = 0; m_det = 0;
    model_reseed();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset values visible at the ports
    check("R1", tx_data_o, 1'b0, "tx_data_o after reset");
    check("R1", det_ref_o, 1'b0, "det_ref_o after reset");

    // R1 R2: default pass-through on tclk_en
    for (int i = 0; i < 12; i++) step(1, 0, (i % 3) == 1, 0, 0, 0, 0, "R2");
    // R10: mclk_en ignored while bit 2 = 0, output holds
    for (int i = 0; i < 4; i++) step(0, 1, i[0], 0, 0, 0, 0, "R10");
    // R3: zeros on mclk_en
    wr(0, 8'b0000_0100, "R3");
    for (int i = 0; i < 6; i++) step(0, 1, 1, 0, 0, 0, 0, "R3");
    for (int i = 0; i < 4; i++) step(1, 0, 1, 0, 0, 0, 0, "R10");
    // R4: all ones, R9: auto ones ignored outside pattern 00
    wr(0, 8'b0001_0001, "R4");
    for (int i = 0; i < 6; i++) step(1, 0, 0, i[0], 0, 0, 0, "R4");
    wr(0, 8'b0001_0010, "R9");
    for (int i = 0; i < 20; i++) step(1, 0, 0, 1, 0, 0, 0, "R9");
    // R9: auto ones in pattern 00 with toggling los
    wr(0, 8'b0001_0000, "R9");
    for (int i = 0; i < 10; i++) step(1, 0, i[1], i[0], 0, 0, 0, "R9");
    wr(0, 8'b0001_0100, "R9");
    for (int i = 0; i < 6; i++) step(0, 1, 0, i[0], 0, 0, 0, "R9");
    // R5: E1 sequence
    wr(0, 8'b0000_0010, "R5");
    for (int i = 0; i < 300; i++) step(1, 0, 0, 0, 0, 0, 0, "R5");
    // R8 R11: invert without reseed
    wr(0, 8'b0000_1010, "R8");
    for (int i = 0; i < 100; i++) step(1, 0, 0, 0, 0, 0, 0, "R8");
    // R7: default code then a new code
    wr(0, 8'b0000_0011, "R7");
    for (int i = 0; i < 12; i++) step(1, 0, 0, 0, 0, 0, 0, "R7");
    wr(1, 8'b0001_0110, "R7");
    for (int i = 0; i < 7; i++) step(1, 0, 0, 0, 0, 0, 0, "R7");
    wr(0, 8'b0000_0001, "R7");
    wr(0, 8'b0000_0011, "R7");
    for (int i = 0; i < 11; i++) step(1, 0, 0, 0, 0, 0, 0, "R7");
    // R6: T1 sequence with zero-run limit
    t1_mode = 1'b1;
    wr(0, 8'b0000_0010, "R6");
    for (int i = 0; i < 80000; i++) step(1, 0, 0, 0, 0, 0, 0, "R6");
    // R11: reseed after a change away and back
    wr(0, 8'b0000_0001, "R11");
    wr(0, 8'b0000_0010, "R11");
    for (int i = 0; i < 60; i++) step(1, 0, 0, 0, 0, 0, 0, "R11");
    step(0, 0, 0, 0, 0, 0, 0, "R10");
    repeat (3) @(posedge clk);
    #3;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule